// File: doc/BRIEF.md
# Debug Data Address Watchpoint Comparator

This block watches the data accesses of a processor core for an on-chip debug facility. Each access arrives as an address, a valid strobe, a privilege flag and a data-space flag. Two programmable reference registers, A and B, and a packed control word decide when a watchpoint event fires. Either the two references act as two independent exact-match watchpoints, or reference B is reused as a bit mask or as the upper bound of a range, with reference A as the lower bound. In that case channel B goes quiet.

Each channel has its own privilege and address-space qualifier. In the combined modes only channel A's qualifiers apply. Channel A can also be made to depend on an instruction-address compare hit that arrives with the same access. While that link is active, the instruction compare hit is not forwarded as an event of its own. The outputs are registered single-cycle pulses, one per channel plus the forwarded instruction compare event. Status capture, exception flow and the instruction comparator itself live outside the block.

Top module: `wp_watch`

## Requirements
- R1: An active-low asynchronous reset clears reference A, reference B and the control word to zero, which selects exact compare with no qualification. All event outputs are low during reset.
- R2: On a rising clock edge, `wr_ref_a_i`, `wr_ref_b_i` and `wr_ctrl_i` each load `wr_data_i` into their own register. The control word takes `wr_data_i[10:0]` with this layout: [10:9] privilege qualifier A, [8:7] space qualifier A, [6:5] privilege qualifier B, [4:3] space qualifier B, [2:1] compare mode, [0] link enable.
- R3: `ev_a_o` and `ev_b_o` are registered pulses. They are high in the cycle after the access is sampled, and only if `acc_valid_i` was high at that edge.
- R4: Mode 00 is exact compare. Channel A fires when the address equals reference A, and channel B fires when the address equals reference B, each under its own qualifiers.
- R5: Mode 01 is masked compare. Channel A fires when (address AND ref B) equals (ref A AND ref B). Channel B never fires.
- R6: Mode 10 is inclusive range. Channel A fires when ref A <= address < ref B, compared unsigned. Channel B never fires.
- R7: Mode 11 is exclusive range. Channel A fires when address < ref A or address >= ref B. Channel B never fires.
- R8: Privilege qualifier codes are: 00 and 01 ignore the privilege flag, 10 requires `acc_user_i`=0 (supervisor), and 11 requires `acc_user_i`=1 (user).
- R9: Space qualifier codes are: 00 adds no condition, 10 requires `acc_ds_i`=0, 11 requires `acc_ds_i`=1, and 01 (real-address compare, not provided) blocks the channel entirely.
- R10: In modes 01, 10 and 11 only the channel A qualifiers gate the combined result. The channel B qualifiers have no effect.
- R11: When the link bit is 1, channel A fires only if `iac_hit_i` is high in the same cycle as the access.
- R12: `iac_ev_o` pulses in the cycle after `iac_hit_i` is high, unless the link bit is 1, in which case it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_ref_a_i | input | 1 | Load reference A |
| wr_ref_b_i | input | 1 | Load reference B |
| wr_ctrl_i | input | 1 | Load control word |
| wr_data_i | input | AW (32) | Write data |
| acc_valid_i | input | 1 | Data access strobe |
| acc_addr_i | input | AW (32) | Data access address |
| acc_user_i | input | 1 | 1 = user privilege, 0 = supervisor |
| acc_ds_i | input | 1 | Data-space flag |
| iac_hit_i | input | 1 | Instruction compare hit for the same instruction |
| ev_a_o | output | 1 | Channel A event pulse |
| ev_b_o | output | 1 | Channel B event pulse |
| iac_ev_o | output | 1 | Forwarded instruction compare event |

## Verification
Every event output is due exactly one clock after the edge that samples the access. A register write takes effect at its own edge, so an access driven in the next cycle already uses the new value. The bench drives each access on a falling edge and lets one rising edge pass. It samples the outputs on the following falling edge, then drops the strobe and checks that the pulse is gone one cycle later. Range bounds are probed on both sides of each limit to pin down which comparisons are inclusive.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int CTRL_W = 11;

  typedef enum logic [1:0] {
    MODE_EXACT     = 2'b00,
    MODE_MASK      = 2'b01,
    MODE_IN_RANGE  = 2'b10,
    MODE_OUT_RANGE = 2'b11
  } cmp_mode_e;

  // packed MSB first: matches control word layout
  typedef struct packed {
    logic [1:0] priv_a;
    logic [1:0] space_a;
    logic [1:0] priv_b;
    logic [1:0] space_b;
    cmp_mode_e  mode;
    logic       link;
  } wp_ctrl_t;
endpackage

// File: rtl/wp_qual.sv
module wp_qual (
  input  logic [1:0] priv_i,
  input  logic [1:0] space_i,
  input  logic       user_i,
  input  logic       ds_i,
  output logic       ok_o
);
  logic priv_ok, space_ok;

  always_comb begin
    unique case (priv_i)
      2'b10:   priv_ok = ~user_i;
      2'b11:   priv_ok = user_i;
      default: priv_ok = 1'b1;
    endcase
    unique case (space_i)
      2'b00:   space_ok = 1'b1;
      2'b01:   space_ok = 1'b0;  // real-address compare not provided
      2'b10:   space_ok = ~ds_i;
      default: space_ok = ds_i;
    endcase
  end

  assign ok_o = priv_ok & space_ok;
endmodule

// File: rtl/wp_addr_cmp.sv
module wp_addr_cmp
  import wp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ref_a_i,
  input  logic [AW-1:0] ref_b_i,
  input  cmp_mode_e     mode_i,
  output logic          hit_a_o,
  output logic          hit_b_o
);
  logic eq_a, eq_b, ge_a, lt_b, mask_eq;

  assign eq_a    = (addr_i == ref_a_i);
  assign eq_b    = (addr_i == ref_b_i);
  assign ge_a    = (addr_i >= ref_a_i);
  assign lt_b    = (addr_i <  ref_b_i);
  assign mask_eq = ((addr_i & ref_b_i) == (ref_a_i & ref_b_i));

  always_comb begin
    hit_b_o = 1'b0;
    unique case (mode_i)
      MODE_EXACT: begin
        hit_a_o = eq_a;
        hit_b_o = eq_b;
      end
      MODE_MASK:     hit_a_o = mask_eq;
      MODE_IN_RANGE: hit_a_o = ge_a & lt_b;
      default:       hit_a_o = ~ge_a | ~lt_b;
    endcase
  end
endmodule

// File: rtl/wp_watch.sv
module wp_watch
  import wp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ref_a_i,
  input  logic          wr_ref_b_i,
  input  logic          wr_ctrl_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          acc_user_i,
  input  logic          acc_ds_i,
  input  logic          iac_hit_i,
  output logic          ev_a_o,
  output logic          ev_b_o,
  output logic          iac_ev_o
);
  localparam int NCH = 2;

  logic [AW-1:0] ref_a_q, ref_b_q;
  wp_ctrl_t      ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_a_q <= '0;
      ref_b_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_ref_a_i) ref_a_q <= wr_data_i;
      if (wr_ref_b_i) ref_b_q <= wr_data_i;
      if (wr_ctrl_i)  ctrl_q  <= wp_ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end
  end

  logic [NCH-1:0][1:0] priv_sel, space_sel;
  logic [NCH-1:0]      qual_ok, hit;

  assign priv_sel  = {ctrl_q.priv_b,  ctrl_q.priv_a};
  assign space_sel = {ctrl_q.space_b, ctrl_q.space_a};

  for (genvar c = 0; c < NCH; c++) begin : g_qual
    wp_qual u_qual (
      .priv_i  (priv_sel[c]),
      .space_i (space_sel[c]),
      .user_i  (acc_user_i),
      .ds_i    (acc_ds_i),
      .ok_o    (qual_ok[c])
    );
  end

  wp_addr_cmp #(.AW(AW)) u_cmp (
    .addr_i  (acc_addr_i),
    .ref_a_i (ref_a_q),
    .ref_b_i (ref_b_q),
    .mode_i  (ctrl_q.mode),
    .hit_a_o (hit[0]),
    .hit_b_o (hit[1])
  );

  logic ev_a_d, ev_b_d;
  assign ev_a_d = acc_valid_i & hit[0] & qual_ok[0] & (~ctrl_q.link | iac_hit_i);
  assign ev_b_d = acc_valid_i & hit[1] & qual_ok[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_a_o   <= 1'b0;
      ev_b_o   <= 1'b0;
      iac_ev_o <= 1'b0;
    end else begin
      ev_a_o   <= ev_a_d;
      ev_b_o   <= ev_b_d;
      iac_ev_o <= iac_hit_i & ~ctrl_q.link;  // linked hit is consumed by channel A
    end
  end
endmodule

// File: rtl/wp_watch_chk.sv
module wp_watch_chk
  import wp_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_valid_i,
  input logic [AW-1:0] acc_addr_i,
  input logic          iac_hit_i,
  input logic [AW-1:0] ref_a_q,
  input wp_ctrl_t      ctrl_q,
  input logic          ev_a_o,
  input logic          ev_b_o,
  input logic          iac_ev_o
);
  assert_no_event_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> (!ev_a_o && !ev_b_o));

  assert_exact_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && ctrl_q.mode == MODE_EXACT && ctrl_q.priv_a == 2'b00 &&
     ctrl_q.space_a == 2'b00 && !ctrl_q.link && acc_addr_i == ref_a_q) |=> ev_a_o);

  assert_b_quiet_combined_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.mode != MODE_EXACT) |=> !ev_b_o);

  assert_real_space_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.space_a == 2'b01) |=> !ev_a_o);

  assert_link_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.link && !iac_hit_i) |=> !ev_a_o);

  assert_iac_consumed_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.link |=> !iac_ev_o);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!ev_a_o && !ev_b_o && !iac_ev_o);
    end
  end
endmodule

bind wp_watch wp_watch_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_addr_i  (acc_addr_i),
  .iac_hit_i   (iac_hit_i),
  .ref_a_q     (ref_a_q),
  .ctrl_q      (ctrl_q),
  .ev_a_o      (ev_a_o),
  .ev_b_o      (ev_b_o),
  .iac_ev_o    (iac_ev_o)
);

// File: tb/wp_watch_tb.sv
`timescale 1ns/1ps
module wp_watch_tb;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_ref_a_i = 1'b0, wr_ref_b_i = 1'b0, wr_ctrl_i = 1'b0;
  logic [AW-1:0] wr_data_i = '0;
  logic          acc_valid_i = 1'b0;
  logic [AW-1:0] acc_addr_i = '0;
  logic          acc_user_i = 1'b0, acc_ds_i = 1'b0, iac_hit_i = 1'b0;
  logic          ev_a_o, ev_b_o, iac_ev_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  wp_watch #(.AW(AW)) u_dut (.*);

  function automatic logic [AW-1:0] mk_ctrl(logic [1:0] pa, logic [1:0] sa,
      logic [1:0] pb, logic [1:0] sb, logic [1:0] md, logic lk);
    return {{(AW-11){1'b0}}, pa, sa, pb, sb, md, lk};
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [AW-1:0] d);
    @(negedge clk_i);
    wr_data_i  = d;
    wr_ref_a_i = (sel == 0);
    wr_ref_b_i = (sel == 1);
    wr_ctrl_i  = (sel == 2);
    @(negedge clk_i);
    wr_ref_a_i = 1'b0; wr_ref_b_i = 1'b0; wr_ctrl_i = 1'b0;
  endtask

  // drive access, sample one clock later, then confirm the pulse ends (R3)
  task automatic acc(string req, logic [AW-1:0] a, logic v, logic u, logic ds,
      logic ih, logic ea, logic eb, logic ei);
    @(negedge clk_i);
    acc_addr_i = a; acc_valid_i = v; acc_user_i = u; acc_ds_i = ds; iac_hit_i = ih;
    @(negedge clk_i);
    acc_valid_i = 1'b0; iac_hit_i = 1'b0;
    check({req, " ev_a"}, ev_a_o, ea);
    check({req, " ev_b"}, ev_b_o, eb);
    check({req, " iac_ev"}, iac_ev_o, ei);
    @(negedge clk_i);
    check("R3 pulse ends", ev_a_o | ev_b_o | iac_ev_o, 1'b0);
  endtask

  task automatic t_reset;
    #1;
    check("R1 reset ev_a", ev_a_o, 1'b0);
    check("R1 reset ev_b", ev_b_o, 1'b0);
    check("R1 reset iac",  iac_ev_o, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    acc("R1 zero refs exact", 32'h0, 1, 1, 1, 0, 1, 1, 0);
  endtask

  task automatic t_exact;
    wr(0, 32'h1000); wr(1, 32'h2000); wr(2, mk_ctrl(0, 0, 0, 0, 2'b00, 0));
    acc("R4 hit A",  32'h1000, 1, 0, 0, 0, 1, 0, 0);
    acc("R4 hit B",  32'h2000, 1, 0, 0, 0, 0, 1, 0);
    acc("R4 miss",   32'h1004, 1, 0, 0, 0, 0, 0, 0);
    acc("R3 no valid", 32'h1000, 0, 0, 0, 0, 0, 0, 0);
    acc("R2 write applied", 32'h2000, 1, 1, 0, 0, 0, 1, 0);
  endtask

  task automatic t_mask;
    wr(0, 32'h0000_1200); wr(1, 32'hFFFF_FF00); wr(2, mk_ctrl(0, 0, 0, 0, 2'b01, 0));
    acc("R5 mask hit",  32'h0000_1234, 1, 0, 0, 0, 1, 0, 0);
    acc("R5 mask miss", 32'h0000_1334, 1, 0, 0, 0, 0, 0, 0);
    acc("R5 B quiet",   32'hFFFF_FF00, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_in_range;
    wr(0, 32'h100); wr(1, 32'h200); wr(2, mk_ctrl(0, 0, 0, 0, 2'b10, 0));
    acc("R6 low bound",   32'h100, 1, 0, 0, 0, 1, 0, 0);
    acc("R6 top inside",  32'h1FF, 1, 0, 0, 0, 1, 0, 0);
    acc("R6 high bound",  32'h200, 1, 0, 0, 0, 0, 0, 0);
    acc("R6 below",       32'h0FF, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_out_range;
    wr(2, mk_ctrl(0, 0, 0, 0, 2'b11, 0));
    acc("R7 below",      32'h0FF, 1, 0, 0, 0, 1, 0, 0);
    acc("R7 low bound",  32'h100, 1, 0, 0, 0, 0, 0, 0);
    acc("R7 inside",     32'h1FF, 1, 0, 0, 0, 0, 0, 0);
    acc("R7 high bound", 32'h200, 1, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_priv;
    wr(0, 32'h40); wr(1, 32'h40); wr(2, mk_ctrl(2'b10, 0, 2'b11, 0, 2'b00, 0));
    acc("R8 supervisor", 32'h40, 1, 0, 0, 0, 1, 0, 0);
    acc("R8 user",       32'h40, 1, 1, 0, 0, 0, 1, 0);
    wr(2, mk_ctrl(2'b01, 0, 2'b01, 0, 2'b00, 0));
    acc("R8 code 01 ignores", 32'h40, 1, 1, 0, 0, 1, 1, 0);
  endtask

  task automatic t_space;
    wr(2, mk_ctrl(0, 2'b10, 0, 2'b11, 2'b00, 0));
    acc("R9 ds0", 32'h40, 1, 0, 0, 0, 1, 0, 0);
    acc("R9 ds1", 32'h40, 1, 0, 1, 0, 0, 1, 0);
    wr(2, mk_ctrl(0, 2'b01, 0, 2'b00, 2'b00, 0));
    acc("R9 real blocks A", 32'h40, 1, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_combined_qual;
    wr(0, 32'h100); wr(1, 32'h200);
    wr(2, mk_ctrl(2'b00, 2'b00, 2'b11, 2'b01, 2'b10, 0));
    acc("R10 B quals ignored", 32'h180, 1, 0, 0, 0, 1, 0, 0);
    wr(2, mk_ctrl(2'b11, 2'b00, 2'b00, 2'b00, 2'b10, 0));
    acc("R10 A quals apply", 32'h180, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_link;
    wr(0, 32'h80); wr(1, 32'h0); wr(2, mk_ctrl(0, 0, 0, 0, 2'b00, 1));
    acc("R11 no iac",   32'h80, 1, 0, 0, 0, 0, 0, 0);
    acc("R11 with iac", 32'h80, 1, 0, 0, 1, 1, 0, 0);
    acc("R12 linked iac hidden", 32'h84, 0, 0, 0, 1, 0, 0, 0);
    wr(2, mk_ctrl(0, 0, 0, 0, 2'b00, 0));
    acc("R12 unlinked iac", 32'h84, 0, 0, 0, 1, 0, 0, 1);
    acc("R11 unlinked A",   32'h80, 1, 0, 0, 0, 1, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_exact();
    t_mask();
    t_in_range();
    t_out_range();
    t_priv();
    t_space();
    t_combined_qual();
    t_link();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule